// File: doc/BRIEF.md
# Dual-Rail Power-Good Qualifier

This block drives the power-good indication for a pair of step-down converters. Each converter has an enable bit and an in-window flag. The flag comes from an external window comparator that already applies the threshold hysteresis. The low-side limits are 91% of nominal on the way up and 87% on the way down. The high-side limits are 112% on the way up and 109% on the way down. The block's output, `pg_pull_low`, models an open-drain pin: 1 means the pin is pulled low, and 0 means it is released so that an external pull-up can raise it.

Only enabled rails are monitored. When the combined status becomes good, it must stay good for a programmable time before the pin is released. The time is selected by a 2-bit code from 1, 50, 150 and 200 ms. When the status goes bad, the pin is pulled low after a short fixed interval. Time is counted in ticks of an external 1 µs strobe. A parameter sets the number of ticks per millisecond, and another sets the length of the bad-status interval in ticks.

Top module: `pg_dual_rail_monitor`

## Requirements
- R1: With both rails enabled (`rail_en`=2'b11), the combined status is good only when both `rail_ok` bits are 1. The pin is released only after that has held, and a bad status on either rail pulls it low.
- R2: With one rail enabled (`rail_en`=2'b01 or 2'b10), only that rail's `rail_ok` bit matters. The other rail's flag has no effect on the output.
- R3: With `rail_en`=2'b00, `pg_pull_low` is 1 in the same cycle and stays 1. Re-enabling a rail needs the full release delay again.
- R4: `dly_sel` selects the release delay: 2'b00 = 1 ms, 2'b01 = 50 ms, 2'b10 = 150 ms, 2'b11 = 200 ms, each ms being `TICKS_PER_MS` ticks. The pin is released at the clock edge of the Nth consecutive tick with good status, where N is the selected delay in ticks.
- R5: Once the pin is released, a bad status pulls it low at the edge of the `FALL_TICKS`th consecutive tick with bad status. A bad spell that is shorter than this leaves the pin released.
- R6: If the status drops out of good while the release delay is counting, the count restarts from zero. The full delay of unbroken good status is then required.
- R7: While `rst_n` is low, `pg_pull_low` is 1 and both timers are cleared. The internal reset is released two clock edges after `rst_n` rises.
- R8: The delay code is latched on the first good tick of a count. A change to `dly_sel` during a count takes effect at the next count start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe every microsecond |
| rail_en | input | 2 | Per-rail monitor enable (bit 0 = rail A, bit 1 = rail B) |
| rail_ok | input | 2 | Per-rail in-window flag from the external comparators |
| dly_sel | input | 2 | Release delay code |
| pg_pull_low | output | 1 | 1 = pin pulled low, 0 = pin released |

## Verification
The disable path (R3) is combinational and is sampled in the same half cycle as the stimulus. The release is due exactly N edges after good status is first applied, with N equal to the selected milliseconds times `TICKS_PER_MS`. The pull-low is due exactly `FALL_TICKS` edges after bad status is applied. The bench drives the tick every cycle and changes inputs on falling edges. Each timed result is therefore checked twice, once a single edge before it is due, where the old value must still hold, and once on the edge where it is due. All sixteen enable and flag combinations, all four delay codes, restart, glitch filtering and code changes are run with a small tick-per-ms setting.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;

  typedef enum logic [1:0] {
    DLY_1MS   = 2'b00,
    DLY_50MS  = 2'b01,
    DLY_150MS = 2'b10,
    DLY_200MS = 2'b11
  } pg_dly_e;

  localparam int unsigned PG_MAX_MS = 200;

  // Delay in milliseconds for a release code.
  function automatic int unsigned pg_code_ms(input logic [1:0] code);
    case (pg_dly_e'(code))
      DLY_1MS:   pg_code_ms = 1;
      DLY_50MS:  pg_code_ms = 50;
      DLY_150MS: pg_code_ms = 150;
      default:   pg_code_ms = PG_MAX_MS;
    endcase
  endfunction

endpackage

// File: rtl/pg_reset_sync.sv
`timescale 1ns/1ps
module pg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign sync_d[s] = 1'b1;
      end else begin : g_next
        assign sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pg_rail_qualify.sv
`timescale 1ns/1ps
module pg_rail_qualify #(
  parameter int NUM_RAILS = 2
) (
  input  logic [NUM_RAILS-1:0] rail_en,
  input  logic [NUM_RAILS-1:0] rail_ok,
  output logic                 any_en,
  output logic                 all_good
);

  logic [NUM_RAILS-1:0] rail_pass;

  // A disabled rail never blocks; an enabled rail must be in window.
  generate
    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
      assign rail_pass[r] = rail_ok[r] | ~rail_en[r];
    end
  endgenerate

  assign any_en   = |rail_en;
  assign all_good = any_en & (&rail_pass);

endmodule

// File: rtl/pg_release_timer.sv
`timescale 1ns/1ps
module pg_release_timer #(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       good,
  input  logic       released,
  input  logic [1:0] dly_sel,
  output logic       done
);

  localparam int unsigned MAX_TICKS = pg_pkg::PG_MAX_MS * TICKS_PER_MS;
  localparam int          CW        = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic [CW-1:0] sel_lim;
  logic [CW-1:0] act_lim;
  logic          counting;
  logic          start;

  assign sel_lim  = CW'(pg_pkg::pg_code_ms(dly_sel) * TICKS_PER_MS);
  assign counting = good & ~released;
  assign start    = counting & tick & (cnt_q == '0);
  assign act_lim  = (cnt_q == '0) ? sel_lim : lim_q;
  assign done     = counting & tick & ((cnt_q + 1'b1) == act_lim);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (!counting) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (start) begin
      lim_d = sel_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CW'(pg_pkg::pg_code_ms(pg_pkg::DLY_150MS) * TICKS_PER_MS);
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assert_restart_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!good) |=> (cnt_q == '0));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_TICKS));

  assert_latched_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && tick && cnt_q != '0 && !done) |=> (lim_q == $past(lim_q)));

endmodule

// File: rtl/pg_drop_filter.sv
`timescale 1ns/1ps
module pg_drop_filter #(
  parameter int FALL_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic good,
  input  logic released,
  output logic done
);

  localparam int CW = $clog2(FALL_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bad_hold;

  assign bad_hold = released & ~good;
  assign done     = bad_hold & tick & ((cnt_q + 1'b1) == CW'(FALL_TICKS));

  always_comb begin
    cnt_d = cnt_q;
    if (!bad_hold) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assert_drop_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FALL_TICKS));

  assert_good_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    good |=> (cnt_q == '0));

endmodule

// File: rtl/pg_dual_rail_monitor.sv
`timescale 1ns/1ps
module pg_dual_rail_monitor #(
  parameter int TICKS_PER_MS = 1000,
  parameter int FALL_TICKS   = 30,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] rail_en,
  input  logic [1:0] rail_ok,
  input  logic [1:0] dly_sel,
  output logic       pg_pull_low
);

  logic rst_i_n;
  logic any_en;
  logic all_good;
  logic rise_done;
  logic fall_done;
  logic released_q, released_d;

  pg_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pg_rail_qualify #(.NUM_RAILS(2)) u_qual (
    .rail_en  (rail_en),
    .rail_ok  (rail_ok),
    .any_en   (any_en),
    .all_good (all_good)
  );

  pg_release_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_rise (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick),
    .good     (all_good),
    .released (released_q),
    .dly_sel  (dly_sel),
    .done     (rise_done)
  );

  pg_drop_filter #(.FALL_TICKS(FALL_TICKS)) u_fall (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick),
    .good     (all_good),
    .released (released_q),
    .done     (fall_done)
  );

  always_comb begin
    released_d = released_q;
    if (!any_en) begin
      released_d = 1'b0;
    end else if (rise_done) begin
      released_d = 1'b1;
    end else if (fall_done) begin
      released_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      released_q <= 1'b0;
    end else begin
      released_q <= released_d;
    end
  end

  assign pg_pull_low = ~released_q | ~any_en;

  assert_off_low_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rail_en == 2'b00) |-> pg_pull_low);

  assert_release_needs_good_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(released_q) |-> $past(all_good));

  assert_single_rail_hold_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (released_q && rail_en == 2'b01 && rail_ok[0]) |=> released_q);

  assert_drop_needs_bad_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($fell(released_q) && $past(any_en)) |-> !$past(all_good));

endmodule

// File: tb/pg_dual_rail_monitor_tb.sv
`timescale 1ns/1ps
module pg_dual_rail_monitor_tb_top;

  localparam int TPM  = 4;
  localparam int FALL = 3;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [1:0] rail_en;
  logic [1:0] rail_ok;
  logic [1:0] dly_sel;
  logic       pg_pull_low;

  int n_chk;
  int n_fail;

  pg_dual_rail_monitor #(.TICKS_PER_MS(TPM), .FALL_TICKS(FALL)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rail_en     (rail_en),
    .rail_ok     (rail_ok),
    .dly_sel     (dly_sel),
    .pg_pull_low (pg_pull_low)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int code_ticks(input int code);
    int ms;
    ms = (code == 0) ? 1 : (code == 1) ? 50 : (code == 2) ? 150 : 200;
    return ms * TPM;
  endfunction

  function automatic logic exp_good(input logic [1:0] en, input logic [1:0] ok);
    if (en == 2'b00) return 1'b0;
    return ((ok | ~en) == 2'b11);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pg_pull_low=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    rail_en = 2'b00;
    rail_ok = 2'b00;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  // Drive both rails good and wait for the release.
  task automatic release_now(input logic [1:0] code);
    dly_sel = code;
    rail_en = 2'b11;
    rail_ok = 2'b11;
    cyc(code_ticks(int'(code)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    tick    = 1'b1;
    dly_sel = 2'b00;
    rst_n   = 1'b0;
    rail_en = 2'b00;
    rail_ok = 2'b00;
    cyc(1);

    // R7: reset state with good inputs applied
    rail_en = 2'b11;
    rail_ok = 2'b11;
    cyc(3);
    chk(pg_pull_low, 1'b1, "R7 held low in reset");
    do_reset();
    chk(pg_pull_low, 1'b1, "R7 low after reset");

    // R1/R2/R3: sweep every enable/flag combination with the 1 ms code
    for (int e = 0; e < 4; e++) begin
      for (int o = 0; o < 4; o++) begin
        string tag;
        tag = (e == 3) ? "R1" : (e == 0) ? "R3" : "R2";
        do_reset();
        dly_sel = 2'b00;
        rail_en = 2'(e);
        rail_ok = 2'(o);
        cyc(code_ticks(0) - 1);
        chk(pg_pull_low, 1'b1, {tag, " before delay"});
        cyc(1);
        chk(pg_pull_low, ~exp_good(2'(e), 2'(o)), {tag, " at delay"});
      end
    end

    // R4: every delay code, checked one edge early and on time
    for (int c = 0; c < 4; c++) begin
      do_reset();
      dly_sel = 2'(c);
      rail_en = 2'b11;
      rail_ok = 2'b11;
      cyc(code_ticks(c) - 1);
      chk(pg_pull_low, 1'b1, "R4 one edge early");
      cyc(1);
      chk(pg_pull_low, 1'b0, "R4 released on time");
    end

    // R6: drop during the count restarts the delay
    do_reset();
    dly_sel = 2'b01;
    rail_en = 2'b11;
    rail_ok = 2'b11;
    cyc(100);
    rail_ok = 2'b01;
    cyc(1);
    rail_ok = 2'b11;
    cyc(code_ticks(1) - 1);
    chk(pg_pull_low, 1'b1, "R6 restart not yet released");
    cyc(1);
    chk(pg_pull_low, 1'b0, "R6 released after full delay");

    // R5: short bad spell is filtered, full spell pulls low
    rail_ok = 2'b10;
    cyc(FALL - 1);
    chk(pg_pull_low, 1'b0, "R5 short drop filtered");
    rail_ok = 2'b11;
    cyc(2);
    chk(pg_pull_low, 1'b0, "R5 still released");
    rail_ok = 2'b00;
    cyc(FALL - 1);
    chk(pg_pull_low, 1'b0, "R5 one edge before drop");
    cyc(1);
    chk(pg_pull_low, 1'b1, "R5 pulled low on time");

    // R2: with only rail A enabled rail B flag is ignored
    do_reset();
    dly_sel = 2'b00;
    rail_en = 2'b01;
    rail_ok = 2'b01;
    cyc(code_ticks(0));
    chk(pg_pull_low, 1'b0, "R2 rail A alone released");
    rail_ok = 2'b11;
    cyc(FALL + 2);
    rail_ok = 2'b01;
    cyc(FALL + 2);
    chk(pg_pull_low, 1'b0, "R2 rail B flag ignored");
    rail_en = 2'b10;
    rail_ok = 2'b01;
    cyc(FALL);
    chk(pg_pull_low, 1'b1, "R2 rail B alone bad");

    // R3: disabling both rails pulls low at once, re-enable needs full delay
    do_reset();
    release_now(2'b00);
    chk(pg_pull_low, 1'b0, "R3 released before disable");
    rail_en = 2'b00;
    #1;
    chk(pg_pull_low, 1'b1, "R3 immediate low");
    cyc(1);
    rail_en = 2'b11;
    cyc(code_ticks(0) - 1);
    chk(pg_pull_low, 1'b1, "R3 re-enable waits");
    cyc(1);
    chk(pg_pull_low, 1'b0, "R3 re-enable releases");

    // R8: code change during count applies to the next start only
    do_reset();
    dly_sel = 2'b00;
    rail_en = 2'b11;
    rail_ok = 2'b11;
    cyc(2);
    dly_sel = 2'b11;
    cyc(code_ticks(0) - 2);
    chk(pg_pull_low, 1'b0, "R8 old code kept");
    rail_ok = 2'b00;
    cyc(FALL);
    rail_ok = 2'b11;
    cyc(code_ticks(0));
    chk(pg_pull_low, 1'b1, "R8 new code used");
    cyc(code_ticks(3) - code_ticks(0));
    chk(pg_pull_low, 1'b0, "R8 new code released");

    // R7: reset mid-count clears the timer
    do_reset();
    dly_sel = 2'b00;
    rail_en = 2'b11;
    rail_ok = 2'b11;
    cyc(2);
    rst_n = 1'b0;
    #1;
    chk(pg_pull_low, 1'b1, "R7 async low");
    cyc(1);
    rst_n = 1'b1;
    cyc(2 + code_ticks(0) - 1);
    chk(pg_pull_low, 1'b1, "R7 timer cleared");
    cyc(1);
    chk(pg_pull_low, 1'b0, "R7 full delay after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule